// File: doc/BRIEF.md
# Serial Port Modem Control and Diagnostic Loopback

This block is the modem-control slice of a 16550-compatible serial port. It holds a small control register that the CPU writes and reads at one register offset. The register drives two active-low handshake pins and decides whether the port's interrupt line is driven. It also sits between the transmit and receive shift registers, which live outside this block, and the line pins. There it chooses between normal operation and a self-test loopback.

In loopback the line output idles at the marking level and the line input is ignored. Transmitted bits return straight into the receiver. The four external handshake inputs are replaced by the register's own low four bits, so the status logic downstream sees software-controlled values. The handshake output pins are held at their inactive level while loopback is on. The status values go to the modem status logic with active-high sense, in both modes.

Top module: `uart_mcr_loop`

## Requirements
- R1: After synchronous reset the stored control bits are all 0: `bus_rdata` at offset 4 reads 0x00, `dtr_n` and `rts_n` are 1, `irq_oe` is 0, and loopback is off.
- R2: A write with `bus_we`=1 at `bus_addr`=4 stores `bus_wdata[4:0]` on that clock edge. Bit 0 is DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 loopback. A read at offset 4 returns those five bits, with bits 7:5 always 0 whatever was written to them.
- R3: Writes at any offset other than 4 leave the register unchanged, and `bus_rdata` is 0x00 whenever `bus_addr` is not 4.
- R4: With loopback off, `dtr_n` is the inverse of bit 0 and `rts_n` is the inverse of bit 1.
- R5: `irq_oe` equals bit 3 (OUT2) in both modes. `irq_out` equals `irq_req` when `irq_oe` is 1 and is 0 otherwise.
- R6: With loopback off, `txd` follows `tx_shift_out` and `rx_shift_in` follows `rxd`.
- R7: With loopback on, `txd` is 1, `rx_shift_in` follows `tx_shift_out`, and `rxd` has no effect.
- R8: With loopback off, `msr_cts`, `msr_dsr`, `msr_ri` and `msr_dcd` are the inverses of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`.
- R9: With loopback on, `msr_dsr` is bit 0, `msr_cts` is bit 1, `msr_ri` is bit 2 and `msr_dcd` is bit 3. The four external status inputs have no effect.
- R10: With loopback on, `dtr_n` and `rts_n` are both 1 regardless of bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when offset does not match |
| tx_shift_out | input | 1 | Serial bit from the transmit shift register |
| rx_shift_in | output | 1 | Serial bit to the receive shift register |
| txd | output | 1 | Line output pin |
| rxd | input | 1 | Line input pin |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring indicator input, active low |
| dcd_n | input | 1 | Carrier detect input, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| msr_cts | output | 1 | Clear-to-send status, active high |
| msr_dsr | output | 1 | Data-set-ready status, active high |
| msr_ri | output | 1 | Ring status, active high |
| msr_dcd | output | 1 | Carrier status, active high |
| irq_req | input | 1 | Interrupt request from the priority logic |
| irq_out | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive enable; 0 means high impedance |

## Verification
On every cycle the assertions check four things. A write at the register offset stores its low five bits and any other cycle leaves the register unchanged. In loopback the line output and both handshake pins sit high and the receiver follows the transmitter. The drive enable always matches the OUT2 bit that reads back. The exhaustive sweep covers all 256 write values, each against all combinations of the serial, status and interrupt inputs. Only the sweep shows the cross mapping of control bits onto status outputs, the inversion of pin polarity in normal mode, and that ignored pins truly have no effect.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;

    localparam int DATA_W   = 8;
    localparam int CTL_BITS = 5;

    // Stored control bits, MSB first: bit4 .. bit0
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    // Modem status, active high
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mstat_t;

    function automatic mcr_t mcr_from_byte(input logic [DATA_W-1:0] b);
        return mcr_t'(b[CTL_BITS-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] mcr_to_byte(input mcr_t m);
        return {{(DATA_W-CTL_BITS){1'b0}}, m};
    endfunction

    function automatic mstat_t stat_from_ctl(input mcr_t m);
        mstat_t s;
        s.dsr = m.dtr;
        s.cts = m.rts;
        s.ri  = m.out1;
        s.dcd = m.out2;
        return s;
    endfunction

endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
    import uart_mcr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output mcr_t              ctl,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    logic hit;
    assign hit = (addr == HIT_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (we && hit)
            ctl <= mcr_from_byte(wdata);
    end

    assign rdata = hit ? mcr_to_byte(ctl) : '0;

    assert_write_stores_R2: assert property (@(posedge clk) disable iff (rst)
        (we && hit) |=> (ctl == $past(wdata[CTL_BITS-1:0])));

    assert_other_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !(we && hit) |=> $stable(ctl));

endmodule

// File: rtl/mcr_serial_mux.sv
module mcr_serial_mux (
    input  logic loop,
    input  logic tx_shift_out,
    input  logic rxd,
    output logic txd,
    output logic rx_shift_in
);
    always_comb begin
        if (loop) begin
            txd         = 1'b1;
            rx_shift_in = tx_shift_out;
        end else begin
            txd         = tx_shift_out;
            rx_shift_in = rxd;
        end
    end
endmodule

// File: rtl/mcr_modem_mux.sv
module mcr_modem_mux
    import uart_mcr_pkg::*;
(
    input  mcr_t   ctl,
    input  mstat_t pins_n,
    input  logic   irq_req,
    output logic   dtr_n,
    output logic   rts_n,
    output mstat_t stat,
    output logic   irq_out,
    output logic   irq_oe
);
    always_comb begin
        if (ctl.loop) begin
            dtr_n = 1'b1;
            rts_n = 1'b1;
            stat  = stat_from_ctl(ctl);
        end else begin
            dtr_n = ~ctl.dtr;
            rts_n = ~ctl.rts;
            stat  = ~pins_n;
        end
        irq_oe  = ctl.out2;
        irq_out = irq_req & ctl.out2;
    end
endmodule

// File: rtl/uart_mcr_loop.sv
module uart_mcr_loop
    import uart_mcr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_shift_out,
    output logic              rx_shift_in,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              msr_cts,
    output logic              msr_dsr,
    output logic              msr_ri,
    output logic              msr_dcd,
    input  logic              irq_req,
    output logic              irq_out,
    output logic              irq_oe
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    mcr_t   ctl;
    mstat_t pins_n;
    mstat_t stat;

    assign pins_n.cts = cts_n;
    assign pins_n.dsr = dsr_n;
    assign pins_n.ri  = ri_n;
    assign pins_n.dcd = dcd_n;

    mcr_reg #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .ctl   (ctl),
        .rdata (bus_rdata)
    );

    mcr_serial_mux u_ser (
        .loop         (ctl.loop),
        .tx_shift_out (tx_shift_out),
        .rxd          (rxd),
        .txd          (txd),
        .rx_shift_in  (rx_shift_in)
    );

    mcr_modem_mux u_mdm (
        .ctl     (ctl),
        .pins_n  (pins_n),
        .irq_req (irq_req),
        .dtr_n   (dtr_n),
        .rts_n   (rts_n),
        .stat    (stat),
        .irq_out (irq_out),
        .irq_oe  (irq_oe)
    );

    assign msr_cts = stat.cts;
    assign msr_dsr = stat.dsr;
    assign msr_ri  = stat.ri;
    assign msr_dcd = stat.dcd;

    assert_loop_pins_high_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[4] |-> (dtr_n && rts_n && txd));

    assert_loop_rx_follows_tx_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[4] |-> (rx_shift_in == tx_shift_out));

    assert_oe_matches_out2_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == HIT_ADDR) |-> (irq_oe == bus_rdata[3]));

    assert_no_drive_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        !irq_oe |-> !irq_out);

endmodule

// File: tb/test_uart_mcr_loop.sv
`timescale 1ns/1ps
module test_uart_mcr_loop;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd4;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic tx_shift_out = 1'b0, rxd = 1'b0;
    logic rx_shift_in, txd;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic dtr_n, rts_n, msr_cts, msr_dsr, msr_ri, msr_dcd;
    logic irq_req = 1'b0, irq_out, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    uart_mcr_loop i_uart_mcr_loop (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_shift_out(tx_shift_out), .rx_shift_in(rx_shift_in),
        .txd(txd), .rxd(rxd), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .msr_cts(msr_cts), .msr_dsr(msr_dsr), .msr_ri(msr_ri),
        .msr_dcd(msr_dcd), .irq_req(irq_req), .irq_out(irq_out),
        .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd4;
        #0.5;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cur;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 pins", {6'b0, dtr_n, rts_n}, 8'h03);
        chk("R1 oe", {7'b0, irq_oe}, 8'h00);
        chk("R1 txd", {7'b0, txd}, {7'b0, tx_shift_out});

        for (int v = 0; v < 256; v++) begin
            wr(3'd4, v[7:0]);
            cur = {3'b000, v[4:0]};
            chk("R2 readback", bus_rdata, cur);
            for (int p = 0; p < 128; p++) begin
                logic lp;
                logic [3:0] es;
                tx_shift_out = p[0]; rxd = p[1]; cts_n = p[2];
                dsr_n = p[3]; ri_n = p[4]; dcd_n = p[5]; irq_req = p[6];
                #0.1;
                lp = cur[4];
                // order: dcd ri dsr cts
                if (lp) begin
                    es = {cur[3], cur[2], cur[0], cur[1]};
                    chk("R7 txd", {7'b0, txd}, 8'h01);
                    chk("R7 rx", {7'b0, rx_shift_in}, {7'b0, p[0]});
                    chk("R10 pins", {6'b0, dtr_n, rts_n}, 8'h03);
                    chk("R9 status", {4'b0, msr_dcd, msr_ri, msr_dsr, msr_cts}, {4'b0, es});
                end else begin
                    es = ~{p[5], p[4], p[3], p[2]};
                    chk("R6 txd", {7'b0, txd}, {7'b0, p[0]});
                    chk("R6 rx", {7'b0, rx_shift_in}, {7'b0, p[1]});
                    chk("R4 pins", {6'b0, dtr_n, rts_n}, {6'b0, ~cur[0], ~cur[1]});
                    chk("R8 status", {4'b0, msr_dcd, msr_ri, msr_dsr, msr_cts}, {4'b0, es});
                end
                chk("R5 oe", {7'b0, irq_oe}, {7'b0, cur[3]});
                chk("R5 irq", {7'b0, irq_out}, {7'b0, p[6] & cur[3]});
            end
        end

        // R3 other offsets
        wr(3'd4, 8'h15);
        for (int a = 0; a < 8; a++) begin
            if (a != 4) begin
                wr(a[2:0], 8'hEA);
                bus_addr = a[2:0];
                #0.1;
                chk("R3 read other", bus_rdata, 8'h00);
                bus_addr = 3'd4;
                #0.1;
                chk("R3 unchanged", bus_rdata, 8'h15);
            end
        end

        // R1 reset again clears a loaded register
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #0.5;
        chk("R1 cleared", bus_rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule